// File: doc/BRIEF.md
# Masked Input Change Event Generator

The block watches a word of discrete inputs that some upstream logic presents together with a one-cycle sample strobe. On every accepted strobe it compares the new snapshot with the snapshot it kept from the previous accepted strobe. Every bit that differs and whose channel is enabled becomes one event. An event carries the channel number, a direction flag and the value a free-running cycle counter had when the snapshot was taken.

Events leave one at a time on a valid/ready stream, lowest channel number first. While any event of a snapshot is still waiting, the block reports itself busy and drops further sample strobes. A per-channel enable mask can be rewritten at any time. The stored snapshot always takes the full new input word, whatever the mask says. Typical use is to put a debounced bank of discrete lines behind a small event queue, so that software sees only the edges it asked for.

Top module: `chgev_top`

## Requirements
- R1: Right after reset `evtValid` and `busy` are 0, every channel enable is 1, and the stored snapshot is all zeros, so the first accepted snapshot produces a rising event for each bit that is 1.
- R2: An accepted strobe marks as changed the bits where `sampleData` differs from the stored snapshot, and produces exactly one event for each changed bit whose enable is set.
- R3: An accepted strobe whose data equals the stored snapshot produces no event, and `busy` stays 0.
- R4: Bit i of the enable mask gates channel i. Writing `maskIn` with `maskWe` high loads the whole mask at that clock edge. The mask in force at the capture edge decides which changes become events.
- R5: `evtRise` is 1 when the new value of the channel is 1, and 0 when it is 0.
- R6: An accepted strobe loads the whole new word into the stored snapshot, disabled channels included. A later snapshot therefore compares against it, and no event appears for a masked change once its channel is enabled again.
- R7: Events of one snapshot leave in strictly ascending channel order.
- R8: The timestamp counter is 0 after reset and advances once per clock. Every event of a snapshot carries the counter value at its capture edge.
- R9: While `evtValid` is 1 and `evtReady` is 0, the channel, direction and stamp stay unchanged. Each cycle with both high removes exactly one event.
- R10: From the cycle after an accepted strobe, for as long as events remain, `busy` is 1. A strobe seen while `busy` is 1 is ignored: no snapshot update and no events.
- R11: The first event of a snapshot is valid in the cycle after the capture edge. `busy` falls in the cycle after the last event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Snapshot strobe, one cycle per sample |
| sampleData | input | NUM_CH | Snapshot of the discrete inputs |
| maskWe | input | 1 | Load the enable mask |
| maskIn | input | NUM_CH | New enable mask, bit i for channel i |
| evtValid | output | 1 | An event is presented |
| evtReady | input | 1 | Consumer accepts the presented event |
| evtChan | output | CH_W | Channel number of the event |
| evtRise | output | 1 | 1 for a rising change, 0 for a falling change |
| evtStamp | output | TS_W | Counter value at the capture edge |
| busy | output | 1 | Events of the last snapshot are still pending |

## Verification
The properties take it as given that `sampleStb` counts only while the pending set is empty. They also assume that `evtReady` may move freely in any cycle, and that `sampleData` and `maskIn` matter only in the cycles where they are captured. The stimulus changes every input just after the falling edge and holds each strobe and mask write for exactly one cycle. It decides whether a strobe was accepted from the `busy` level seen on that cycle, and it switches the consumer between always ready, stalled and a pseudo-random ready pattern. This covers both back-pressure and back-to-back acceptance. Dropped strobes are sent on purpose while the consumer is stalled, so that their data can never reach the snapshot unnoticed.

// File: rtl/chgev_pkg.sv
package chgev_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // take a new snapshot this edge
    logic pop;      // retire the presented event this edge
  } chgevCtl_t;

endpackage

// File: rtl/chgev_datapath.sv
module chgev_datapath
  import chgev_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int TS_W   = 32,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  chgevCtl_t         ctl,
  input  logic [NUM_CH-1:0] sampleData,
  input  logic              maskWe,
  input  logic [NUM_CH-1:0] maskIn,
  output logic              anyPending,
  output logic [CH_W-1:0]   evtChan,
  output logic              evtRise,
  output logic [TS_W-1:0]   evtStamp
);

  localparam logic [NUM_CH-1:0] ONE_VEC  = NUM_CH'(1);
  localparam logic [NUM_CH-1:0] ALL_ONES = '1;

  logic [NUM_CH-1:0] prevQ;    // last accepted snapshot
  logic [NUM_CH-1:0] maskQ;    // per-channel enables
  logic [NUM_CH-1:0] pendQ;    // events still to leave
  logic [TS_W-1:0]   tsQ;      // free-running counter
  logic [TS_W-1:0]   stampQ;   // counter latched at capture
  logic [NUM_CH-1:0] changed;
  logic [NUM_CH-1:0] lowOne;
  logic [CH_W-1:0]   pickIdx;

  assign changed = sampleData ^ prevQ;
  assign lowOne  = pendQ & (~pendQ + ONE_VEC);

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendQ[i]) pickIdx = CH_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsQ <= '0;
    else       tsQ <= tsQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       maskQ <= ALL_ONES;
    else if (maskWe) maskQ <= maskIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      pendQ  <= '0;
      stampQ <= '0;
    end else if (ctl.capture) begin
      prevQ  <= sampleData;
      pendQ  <= changed & maskQ;
      stampQ <= tsQ;
    end else if (ctl.pop) begin
      pendQ  <= pendQ & ~lowOne;
    end
  end

  assign anyPending = |pendQ;
  assign evtChan    = pickIdx;
  assign evtRise    = prevQ[pickIdx];
  assign evtStamp   = stampQ;

  // R10: the control only captures when nothing is pending
  p_capture_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !anyPending);

  // R4: no pending bit for a channel disabled at capture time
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (pendQ & ~$past(maskQ)) == '0);

  // R3: identical snapshot yields nothing
  p_no_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && (sampleData == prevQ)) |=> !anyPending);

  // R9: each handshake retires exactly one event
  p_one_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |=> ($countones(pendQ) + 1) == $countones($past(pendQ)));

  // R9: presented event holds while not accepted
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (anyPending && !ctl.pop) |=>
      (anyPending && $stable(evtChan) && $stable(evtRise) && $stable(evtStamp)));

  // R7: channels of one snapshot leave in ascending order
  p_ascend_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |=> (!anyPending || (evtChan > $past(evtChan))));

  // R8: all events of a snapshot share one stamp
  p_stamp_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |=> (!anyPending || $stable(evtStamp)));

endmodule

// File: rtl/chgev_control.sv
module chgev_control
  import chgev_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleStb,
  input  logic      evtReady,
  input  logic      anyPending,
  output chgevCtl_t ctl,
  output logic      evtValid,
  output logic      busy
);

  // A strobe is taken only with an empty pending set; a handshake only
  // when an event is presented.
  assign ctl.capture = sampleStb && !anyPending;
  assign ctl.pop     = anyPending && evtReady;
  assign evtValid    = anyPending;
  assign busy        = anyPending;

  // R10: a strobe arriving while busy never turns into a capture
  p_drop_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && busy) |-> !ctl.capture);

  // R9: no retirement without a presented event
  p_pop_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> (evtValid && evtReady));

endmodule

// File: rtl/chgev_top.sv
module chgev_top
  import chgev_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int TS_W   = 32,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [NUM_CH-1:0] sampleData,
  input  logic              maskWe,
  input  logic [NUM_CH-1:0] maskIn,
  output logic              evtValid,
  input  logic              evtReady,
  output logic [CH_W-1:0]   evtChan,
  output logic              evtRise,
  output logic [TS_W-1:0]   evtStamp,
  output logic              busy
);

  chgevCtl_t ctl;
  logic      anyPending;

  chgev_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleStb  (sampleStb),
    .evtReady   (evtReady),
    .anyPending (anyPending),
    .ctl        (ctl),
    .evtValid   (evtValid),
    .busy       (busy)
  );

  chgev_datapath #(
    .NUM_CH (NUM_CH),
    .TS_W   (TS_W),
    .CH_W   (CH_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleData (sampleData),
    .maskWe     (maskWe),
    .maskIn     (maskIn),
    .anyPending (anyPending),
    .evtChan    (evtChan),
    .evtRise    (evtRise),
    .evtStamp   (evtStamp)
  );

endmodule

// File: tb/tb_chgev_top.sv
module tb_chgev_top;

  localparam int NCH = 32;
  localparam int TSW = 32;
  localparam int CHW = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic           rstN = 1'b0;
  logic           sampleStb = 1'b0;
  logic [NCH-1:0] sampleData = '0;
  logic           maskWe = 1'b0;
  logic [NCH-1:0] maskIn = '0;
  logic           evtValid;
  logic           evtReady = 1'b0;
  logic [CHW-1:0] evtChan;
  logic           evtRise;
  logic [TSW-1:0] evtStamp;
  logic           busy;

  chgev_top #(.NUM_CH(NCH), .TS_W(TSW)) dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .sampleData(sampleData),
    .maskWe(maskWe), .maskIn(maskIn), .evtValid(evtValid), .evtReady(evtReady),
    .evtChan(evtChan), .evtRise(evtRise), .evtStamp(evtStamp), .busy(busy)
  );

  typedef struct packed {
    logic [CHW-1:0] ch;
    logic           rise;
    logic [TSW-1:0] st;
  } ev_t;

  ev_t            expQ[$];
  int             checks = 0;
  int             fails = 0;
  int unsigned    tbCyc = 0;
  logic [NCH-1:0] modelPrev = '0;
  logic [NCH-1:0] modelMask = '1;
  int             readyMode = 0;  // 0 always, 1 pseudo-random, 2 stalled
  logic [15:0]    lfsr = 16'hACE1;
  logic           stallSeen = 1'b0;
  ev_t            stallEv;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // counter mirror and watchdog
  always @(posedge clk) begin
    if (rstN) tbCyc++;
    if (tbCyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", tbCyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // monitor: drives ready, then judges the handshake at the coming edge
  always @(negedge clk) begin
    if (rstN) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evtReady = (readyMode == 0) ? 1'b1 : (readyMode == 2) ? 1'b0 : lfsr[0];
      if (stallSeen) begin
        check(evtValid && evtChan == stallEv.ch && evtRise == stallEv.rise &&
              evtStamp == stallEv.st, "R9", "held event",
              {evtChan, evtRise}, {stallEv.ch, stallEv.rise});
      end
      stallSeen = evtValid && !evtReady;
      stallEv   = '{ch: evtChan, rise: evtRise, st: evtStamp};
      if (evtValid && evtReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected event channel", evtChan, 0);
        end else begin
          ev_t e;
          e = expQ.pop_front();
          check(evtChan == e.ch, "R7", "channel", evtChan, e.ch);
          check(evtRise == e.rise, "R5", "direction", evtRise, e.rise);
          check(evtStamp == e.st, "R8", "stamp", evtStamp, e.st);
        end
      end
    end
  end

  task automatic doSample(input logic [NCH-1:0] d, output bit acc);
    logic [NCH-1:0] ch;
    int n;
    @(negedge clk);
    acc = !busy;
    sampleData = d;
    sampleStb  = 1'b1;
    n = 0;
    if (acc) begin
      ch = d ^ modelPrev;
      for (int i = 0; i < NCH; i++) begin
        if (ch[i] && modelMask[i]) begin
          expQ.push_back('{ch: CHW'(i), rise: d[i], st: tbCyc});
          n++;
        end
      end
      modelPrev = d;
    end
    @(negedge clk);
    sampleStb = 1'b0;
    if (acc) begin
      if (n > 0) check(evtValid && busy, "R11", "valid after capture", evtValid, 1);
      else       check(!busy && !evtValid, "R3", "busy on no change", busy, 0);
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(expQ.size() == 0, "R11", "left in queue when idle", expQ.size(), 0);
  endtask

  task automatic setMask(input logic [NCH-1:0] m);
    @(negedge clk);
    maskWe = 1'b1;
    maskIn = m;
    @(negedge clk);
    maskWe = 1'b0;
    modelMask = m;
  endtask

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    check(!evtValid && !busy, "R1", "outputs in reset", {evtValid, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!evtValid && !busy, "R1", "outputs after reset", {evtValid, busy}, 0);

    // R1 R2 R5: first snapshot against zero
    readyMode = 0;
    doSample(32'h0000_00A5, acc);
    drain();
    // R3: same data
    doSample(32'h0000_00A5, acc);
    drain();
    // R2 R5: mixed rising and falling
    doSample(32'h0000_00F0, acc);
    drain();

    // R4: upper half enabled only
    setMask(32'hFFFF_0000);
    doSample(32'hFFFF_FFFF, acc);
    drain();
    // R6: re-enable; stored snapshot already holds the masked ones
    setMask(32'hFFFF_FFFF);
    doSample(32'hFFFF_FFFF, acc);
    drain();
    doSample(32'h0000_0000, acc);
    drain();

    // R10 R9: stall, strobe while busy is dropped
    readyMode = 2;
    doSample(32'h8000_0001, acc);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R10", "busy while pending", busy, 1);
    doSample(32'h1234_5678, acc);
    check(!acc, "R10", "strobe accepted while busy", acc, 0);
    readyMode = 0;
    drain();
    // R10: the dropped word must not have reached the snapshot
    doSample(32'h8000_0001, acc);
    drain();

    // mixed traffic with random back-pressure
    readyMode = 1;
    for (int k = 0; k < 24; k++) begin
      if (k % 6 == 5) setMask($urandom);
      doSample($urandom, acc);
      drain();
    end
    readyMode = 0;
    setMask('1);
    doSample(32'h5555_AAAA, acc);
    drain();

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule